// File: doc/BRIEF.md
# Streaming Image Gradient Engine

This block takes a stream of 8-bit grayscale pixels in raster order. The stream covers a fixed image of `IMG_W` columns by `IMG_H` rows, which default to 64 by 128. For every pixel of that image the block produces three results:

- a signed vertical-neighbour difference `gx`;
- a signed horizontal-neighbour difference `gy`;
- a magnitude estimate, equal to the absolute value of `gx + gy`.

Any neighbour that falls outside the image counts as zero, so the image behaves as if it sits inside a one-pixel frame of zeros.

Two row buffers hold the two rows above the incoming one. The result for row `r` is therefore produced while row `r+1` streams in. When the last pixel of a frame has been taken, the block emits the final row on its own, one result per cycle, with the row below treated as zero.

Control is a four-state machine:

| State | Role |
|---|---|
| IDLE | Waits for a start-of-frame pixel. |
| FILL | Captures the first row and emits nothing. |
| RUN | Emits one result per accepted pixel. |
| FLUSH | Emits the last row. |

The transitions are:

- IDLE→FILL on a start-of-frame pixel.
- FILL→RUN after the last pixel of row 0.
- RUN→FLUSH after the last pixel of the last row.
- FLUSH→IDLE after `IMG_W` flush cycles.
- FILL→FILL and RUN→FILL on a start-of-frame pixel, which restarts the frame.

Top module: `grad_engine`

## Requirements
- R1: While reset is asserted, and right after it is released, `out_valid` is 0 and `out_gx`, `out_gy` and `out_mag` are 0.
- R2: `out_gx` for image pixel (r,c) equals P(r+1,c) − P(r−1,c). It is a 9-bit two's complement value with range −255..255.
- R3: `out_gy` for (r,c) equals P(r,c+1) − P(r,c−1). It is a 9-bit two's complement value.
- R4: `out_mag` equals |gx + gy|. It is a 10-bit unsigned value, so it is never above 510, and its bit 0 equals gx[0] XOR gy[0].
- R5: Every neighbour with row outside 0..IMG_H−1 or column outside 0..IMG_W−1 reads as 0.
- R6: Each frame produces exactly IMG_W×IMG_H results, in raster order: row 0 first, and left to right within a row.
- R7: No result is emitted while row 0 is arriving. The first result, for (0,0), appears together with the first pixel of row 1.
- R8: The result for (r,c), with r < IMG_H−1, is registered on the clock edge that accepts pixel (r+1,c). A cycle with `in_valid` low during RUN emits nothing.
- R9: After the last pixel is taken, the results for row IMG_H−1 are emitted on IMG_W consecutive cycles with the row below read as 0. Pixels and start-of-frame markers presented during these cycles are ignored.
- R10: A pixel with `in_valid` and `in_sof` both high, in any state except FLUSH, becomes pixel (0,0) of a new frame. Any partial frame is discarded.
- R11: In IDLE, a pixel with `in_sof` low is ignored and produces no result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Pixel strobe |
| in_sof | input | 1 | Marks the first pixel of a frame |
| in_pix | input | 8 | Unsigned pixel value |
| out_valid | output | 1 | Result strobe |
| out_gx | output | 9 | Vertical difference, signed |
| out_gy | output | 9 | Horizontal difference, signed |
| out_mag | output | 10 | Magnitude, \|gx+gy\| |

## Verification
Each result for rows above the last is due on the edge that accepts the pixel directly below it. The bench drives inputs 1 ns after a rising edge and reads outputs on the following falling edge. A result therefore shows up at the first falling edge after the edge that took that pixel. Last-row results follow on the next `IMG_W` falling edges.

A monitor walks the expected raster list once per result seen, so stall cycles cannot shift the comparison. Directed probes check several timing points:

- the exact cycle of the first result;
- the empty cycle after a stall;
- the frame count after the flush window has closed.

// File: rtl/grad_pkg.sv
`timescale 1ns/1ps
package grad_pkg;

    localparam int PIX_W  = 8;
    localparam int DIFF_W = PIX_W + 1;
    localparam int MAG_W  = PIX_W + 2;

    typedef logic [PIX_W-1:0]         pix_t;
    typedef logic signed [DIFF_W-1:0] diff_t;
    typedef logic [MAG_W-1:0]         mag_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FILL  = 2'd1,
        ST_RUN   = 2'd2,
        ST_FLUSH = 2'd3
    } grad_state_e;

    // neighbours of the pixel whose result is being formed
    typedef struct packed {
        pix_t up;
        pix_t down;
        pix_t left;
        pix_t right;
    } nbr_t;

    function automatic mag_t abs_sum(diff_t a, diff_t b);
        logic signed [MAG_W:0] s;
        s = {{(MAG_W + 1 - DIFF_W){a[DIFF_W-1]}}, a}
          + {{(MAG_W + 1 - DIFF_W){b[DIFF_W-1]}}, b};
        if (s[MAG_W]) begin
            s = -s;
        end
        return s[MAG_W-1:0];
    endfunction

endpackage

// File: rtl/grad_ctrl.sv
`timescale 1ns/1ps
module grad_ctrl
    import grad_pkg::*;
#(
    parameter int IMG_W = 64,
    parameter int IMG_H = 128,
    localparam int CW = $clog2(IMG_W),
    localparam int RW = $clog2(IMG_H)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic        in_sof,
    output grad_state_e state_o,
    output logic        wr_en_o,
    output logic [CW-1:0] col_o,
    output logic        flush_o,
    output logic        emit_o,
    output logic        top_row_o
);

    grad_state_e   state_q, state_d;
    logic [CW-1:0] col_q;
    logic [RW-1:0] row_q;
    logic          sof_take, pix_take, col_last, row_last;

    assign sof_take = in_valid && in_sof && (state_q != ST_FLUSH);
    assign pix_take = in_valid && !in_sof &&
                      ((state_q == ST_FILL) || (state_q == ST_RUN));
    assign col_last = (col_q == CW'(IMG_W - 1));
    assign row_last = (row_q == RW'(IMG_H - 1));

    // next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (sof_take) state_d = ST_FILL;
            end
            ST_FILL: begin
                if (sof_take)                  state_d = ST_FILL;
                else if (pix_take && col_last) state_d = ST_RUN;
            end
            ST_RUN: begin
                if (sof_take)                              state_d = ST_FILL;
                else if (pix_take && col_last && row_last) state_d = ST_FLUSH;
            end
            ST_FLUSH: begin
                if (col_last) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // position counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            col_q <= '0;
            row_q <= '0;
        end else if (sof_take) begin
            col_q <= CW'(1);
            row_q <= '0;
        end else if (pix_take || (state_q == ST_FLUSH)) begin
            if (col_last) begin
                col_q <= '0;
                if (!row_last && (state_q != ST_FLUSH)) row_q <= row_q + RW'(1);
            end else begin
                col_q <= col_q + CW'(1);
            end
        end
    end

    // outputs
    always_comb begin
        state_o   = state_q;
        flush_o   = (state_q == ST_FLUSH);
        wr_en_o   = sof_take || pix_take || flush_o;
        col_o     = sof_take ? '0 : col_q;
        emit_o    = (pix_take && (state_q == ST_RUN)) || flush_o;
        top_row_o = (state_q == ST_RUN) && (row_q == RW'(1));
    end

endmodule

// File: rtl/grad_linebuf.sv
`timescale 1ns/1ps
module grad_linebuf
    import grad_pkg::*;
#(
    parameter int IMG_W = 64,
    localparam int CW = $clog2(IMG_W)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [CW-1:0] col,
    input  pix_t          wr_data,
    output pix_t          up_o,
    output pix_t          left_o,
    output pix_t          right_o
);

    // prev_q: row being emitted (newer row), old_q: row above it.
    pix_t prev_q [IMG_W];
    pix_t old_q  [IMG_W];

    logic [CW-1:0] lcol, rcol;

    assign lcol = col - CW'(1);
    assign rcol = col + CW'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < IMG_W; i++) begin
                prev_q[i] <= '0;
                old_q[i]  <= '0;
            end
        end else if (wr_en) begin
            old_q[col]  <= prev_q[col];
            prev_q[col] <= wr_data;
        end
    end

    // left column has already shifted into old_q this row; right has not
    always_comb begin
        up_o    = old_q[col];
        left_o  = (col == '0) ? '0 : old_q[lcol];
        right_o = (col == CW'(IMG_W - 1)) ? '0 : prev_q[rcol];
    end

endmodule

// File: rtl/grad_kernel.sv
`timescale 1ns/1ps
module grad_kernel
    import grad_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  emit,
    input  logic  top_row,
    input  nbr_t  nbr,
    output logic  out_valid,
    output diff_t out_gx,
    output diff_t out_gy,
    output mag_t  out_mag
);

    pix_t  up_eff;
    diff_t gx_c, gy_c;
    mag_t  mag_c;

    always_comb begin
        up_eff = top_row ? '0 : nbr.up;
        gx_c   = $signed({1'b0, nbr.down})  - $signed({1'b0, up_eff});
        gy_c   = $signed({1'b0, nbr.right}) - $signed({1'b0, nbr.left});
        mag_c  = abs_sum(gx_c, gy_c);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_gx    <= '0;
            out_gy    <= '0;
            out_mag   <= '0;
        end else begin
            out_valid <= emit;
            if (emit) begin
                out_gx  <= gx_c;
                out_gy  <= gy_c;
                out_mag <= mag_c;
            end
        end
    end

endmodule

// File: rtl/grad_engine.sv
`timescale 1ns/1ps
module grad_engine
    import grad_pkg::*;
#(
    parameter int IMG_W = 64,
    parameter int IMG_H = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_sof,
    input  logic [7:0]        in_pix,
    output logic              out_valid,
    output logic signed [8:0] out_gx,
    output logic signed [8:0] out_gy,
    output logic [9:0]        out_mag
);

    localparam int CW = $clog2(IMG_W);

    grad_state_e   state_w;
    logic          wr_en, flush, emit, top_row;
    logic [CW-1:0] col;
    pix_t          wr_data, up, left, right;
    nbr_t          nbr;

    grad_ctrl #(.IMG_W(IMG_W), .IMG_H(IMG_H)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_sof    (in_sof),
        .state_o   (state_w),
        .wr_en_o   (wr_en),
        .col_o     (col),
        .flush_o   (flush),
        .emit_o    (emit),
        .top_row_o (top_row)
    );

    // the row below the last one is zero
    assign wr_data = flush ? '0 : in_pix;

    grad_linebuf #(.IMG_W(IMG_W)) u_lb (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .col     (col),
        .wr_data (wr_data),
        .up_o    (up),
        .left_o  (left),
        .right_o (right)
    );

    always_comb begin
        nbr.up    = up;
        nbr.down  = wr_data;
        nbr.left  = left;
        nbr.right = right;
    end

    grad_kernel u_kern (
        .clk       (clk),
        .rst_n     (rst_n),
        .emit      (emit),
        .top_row   (top_row),
        .nbr       (nbr),
        .out_valid (out_valid),
        .out_gx    (out_gx),
        .out_gy    (out_gy),
        .out_mag   (out_mag)
    );

endmodule

// File: rtl/grad_engine_chk.sv
`timescale 1ns/1ps
module grad_engine_chk
    import grad_pkg::*;
#(
    parameter int IMG_W = 64,
    parameter int IMG_H = 128
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_sof,
    input grad_state_e       state,
    input logic              out_valid,
    input logic signed [8:0] out_gx,
    input logic signed [8:0] out_gy,
    input logic [9:0]        out_mag
);

    localparam int MAG_MAX = 2 * ((1 << PIX_W) - 1);
    localparam int TOTAL   = IMG_W * IMG_H;

    int  seen_q;
    logic sof_take;

    assign sof_take = in_valid && in_sof && (state != ST_FLUSH);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         seen_q <= 0;
        else if (sof_take)  seen_q <= 0;
        else if (out_valid) seen_q <= seen_q + 1;
    end

    AST_FILL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FILL) |=> !out_valid); // R7

    AST_STALL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && !in_valid) |=> !out_valid); // R8

    AST_FLUSH_STREAM: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FLUSH) |=> out_valid); // R9

    AST_SOF_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_sof && state != ST_FLUSH) |=> (state == ST_FILL)); // R10

    AST_IDLE_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !(in_valid && in_sof)) |=> (state == ST_IDLE && !out_valid)); // R11

    AST_MAG_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_mag[0] == (out_gx[0] ^ out_gy[0]))); // R4

    AST_MAG_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_mag <= 10'(MAG_MAX))); // R4

    AST_FRAME_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && $past(state) == ST_FLUSH) |->
        (seen_q + int'(out_valid) == TOTAL)); // R6

endmodule

bind grad_engine grad_engine_chk #(.IMG_W(IMG_W), .IMG_H(IMG_H)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_sof    (in_sof),
    .state     (state_w),
    .out_valid (out_valid),
    .out_gx    (out_gx),
    .out_gy    (out_gy),
    .out_mag   (out_mag)
);

// File: tb/sim_grad_engine.sv
`timescale 1ns/1ps
module sim_grad_engine;

    localparam int W = 64;
    localparam int H = 128;
    localparam int N = W * H;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic              in_sof = 1'b0;
    logic [7:0]        in_pix = 8'd0;
    logic              out_valid;
    logic signed [8:0] out_gx, out_gy;
    logic [9:0]        out_mag;

    always #2 clk = ~clk;

    grad_engine #(.IMG_W(W), .IMG_H(H)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
        .in_pix(in_pix), .out_valid(out_valid), .out_gx(out_gx),
        .out_gy(out_gy), .out_mag(out_mag)
    );

    int   checks = 0;
    int   errors = 0;
    int   mon_idx = 0;
    bit   mon_ignore = 1'b0;
    logic [7:0] img [N];

    function automatic int pv(int r, int c);
        if (r < 0 || r >= H || c < 0 || c >= W) return 0;
        return int'(img[r * W + c]);
    endfunction

    function automatic int egx(int k);
        return pv(k / W + 1, k % W) - pv(k / W - 1, k % W);
    endfunction

    function automatic int egy(int k);
        return pv(k / W, k % W + 1) - pv(k / W, k % W - 1);
    endfunction

    function automatic int emag(int k);
        int s;
        s = egx(k) + egy(k);
        return (s < 0) ? -s : s;
    endfunction

    task automatic chk(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // result monitor, reads on the falling edge
    always @(negedge clk) begin
        if (rst_n && out_valid && !mon_ignore) begin
            if (mon_idx >= N) begin
                chk(1'b0, "R6 extra result", mon_idx, N);
            end else begin
                int r, c;
                string tx, ty, tm;
                r = mon_idx / W;
                c = mon_idx % W;
                if (r == H - 1) begin
                    tx = "R9 gx"; ty = "R9 gy"; tm = "R9 mag";
                end else if (r == 0 || c == 0 || c == W - 1) begin
                    tx = "R5 gx"; ty = "R5 gy"; tm = "R5 mag";
                end else begin
                    tx = "R2 gx"; ty = "R3 gy"; tm = "R4 mag";
                end
                chk(int'(out_gx) == egx(mon_idx), tx, int'(out_gx), egx(mon_idx));
                chk(int'(out_gy) == egy(mon_idx), ty, int'(out_gy), egy(mon_idx));
                chk(int'(out_mag) == emag(mon_idx), tm, int'(out_mag), emag(mon_idx));
            end
            mon_idx++;
        end
    end

    task automatic drive(bit v, bit s, logic [7:0] p);
        @(posedge clk);
        #1;
        in_valid = v;
        in_sof   = s;
        in_pix   = p;
    endtask

    task automatic idle(int n);
        repeat (n) drive(1'b0, 1'b0, 8'd0);
    endtask

    task automatic stream(int stall_pct, bit probe, bit noise);
        mon_idx = 0;
        for (int i = 0; i < N; i++) begin
            while (stall_pct > 0 && int'($urandom % 100) < stall_pct)
                drive(1'b0, 1'b0, 8'($urandom));
            drive(1'b1, i == 0, img[i]);
            if (probe && i == W) begin
                @(posedge clk);
                #1 in_valid = 1'b0;
                @(negedge clk);
                #1;
                chk(out_valid === 1'b1, "R7 first result with pixel (1,0)", int'(out_valid), 1);
                chk(mon_idx == 1, "R7 nothing emitted during row 0", mon_idx, 1);
                chk(int'(out_gx) == egx(0), "R8 gx(0,0) one edge after (1,0)", int'(out_gx), egx(0));
                @(negedge clk);
                #1;
                chk(out_valid === 1'b0, "R8 stall cycle emits nothing", int'(out_valid), 0);
            end
        end
        if (noise) begin
            for (int j = 0; j < W - 1; j++)
                drive(1'b1, 1'($urandom % 2), 8'($urandom));
        end
        idle(W + 4);
        chk(mon_idx == N, "R6 results per frame", mon_idx, N);
    endtask

    bit finished = 1'b0;

    initial begin
        #(4 * 150000);
        if (!finished) begin
            chk(1'b0, "R6 watchdog expired", 0, 1);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd90210));

        // R1: reset values
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(out_valid === 1'b0, "R1 out_valid in reset", int'(out_valid), 0);
        chk(out_gx == 0, "R1 gx in reset", int'(out_gx), 0);
        chk(out_gy == 0, "R1 gy in reset", int'(out_gy), 0);
        chk(out_mag == 0, "R1 mag in reset", int'(out_mag), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid === 1'b0, "R1 out_valid after release", int'(out_valid), 0);

        // R11: pixels without start-of-frame in IDLE
        mon_idx = 0;
        repeat (6) drive(1'b1, 1'b0, 8'($urandom));
        idle(4);
        chk(mon_idx == 0, "R11 IDLE pixel produced result", mon_idx, 0);

        // random frame with stalls, timing probe and flush noise (R9)
        for (int i = 0; i < N; i++) img[i] = 8'($urandom);
        stream(20, 1'b1, 1'b1);

        // extreme stripes: differences reach +/-255, magnitude 510
        for (int i = 0; i < N; i++)
            img[i] = (((i / W) % 4 < 2) == ((i % W) % 4 < 2)) ? 8'd255 : 8'd0;
        stream(0, 1'b0, 1'b0);

        // R10: restart inside FILL, then inside RUN, then a full frame
        mon_ignore = 1'b1;
        for (int i = 0; i < N; i++) img[i] = 8'($urandom);
        for (int i = 0; i < 10; i++) drive(1'b1, i == 0, img[i]);
        for (int i = 0; i < 2 * W + W / 2; i++) drive(1'b1, i == 0, img[i]);
        idle(2);
        mon_ignore = 1'b0;
        for (int i = 0; i < N; i++) img[i] = 8'($urandom);
        stream(10, 1'b0, 1'b0);
        chk(mon_idx == N, "R10 restarted frame complete", mon_idx, N);

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule